// File: doc/BRIEF.md
# DAC Code Load and Update Controller

This block is the digital front end of a multi-channel 12-bit voltage-output converter. Each channel has a 16-bit control register and a 16-bit data register that a bus writes. The block turns the stored data into the unsigned code that drives the resistor ladder. It supports an 8-bit or a 12-bit resolution, and straight binary or two's-complement input.

The block also decides when a new code reaches the ladder. A channel's load mode selects one of four moments: the data write itself, the point at which every grouped channel has been written, a rising edge on timer trigger A, or a rising edge on timer trigger B. Adjacent channels can be linked so that they update in the same clock cycle. Each transfer sets the channel's done flag, and the flag raises an interrupt request when the channel enables it.

Each channel runs a two-state controller. In `CH_IDLE`, no written value is waiting. In `CH_PEND`, the staging latch holds a value that has not yet been transferred. A data write without a transfer moves the channel from `CH_IDLE` to `CH_PEND`. A transfer moves it from `CH_PEND` to `CH_IDLE`, even if a write arrives in the same cycle. In every other case the state is held.

Top module: `dacfe_top`

## Requirements
- R1: After reset, every ladder code is 0, no load strobe is high, no interrupt is raised, and every register reads 0.
- R2: A data write stores bits 11..0 into the staging latch. The data register reads back with bits 15..12 equal to 0.
- R3: In 12-bit straight-binary mode (resolution bit 12 = 0, format bit 4 = 0), the ladder code equals the stored bits 11..0. The code changes only in a cycle in which the load strobe is high.
- R4: In two's-complement mode (format bit 4 = 1), the active MSB is inverted to form an offset-binary code. The active MSB is bit 11 of the code in 12-bit mode and bit 7 of the data in 8-bit mode.
- R5: In 8-bit mode (resolution bit 12 = 1), the ladder code is {data[7:0], 4'b0000}.
- R6: With load select (bits 11..10) = 0 on a channel that is not in a group, the code updates at the clock edge that completes the data write. The load strobe is high for that one cycle, and the enable bit is not needed.
- R7: With load select = 1 on a channel that is not in a group, a written value transfers at the first clock edge at which the channel is pending and its enable bit (bit 1) is 1. While enable is 0, the value stays pending.
- R8: Load select = 2 transfers on a rising edge of trigger A, and load select = 3 on a rising edge of trigger B. The strobe appears three clock edges after the input rises. A transfer requires enable = 1. The other trigger and a held-high level cause no transfer.
- R9: The link bit (bit 0) of channel i joins channel i+1 to channel i's group. The lowest channel of a group supplies load select and enable for every member. With load select 0 or 1, the group transfers at one clock edge after every member has been written, and all members strobe in the same cycle.
- R10: The link bit of the highest channel has no effect.
- R11: Every transfer sets the done flag (bit 2). The interrupt request for a channel is the done flag AND the interrupt-enable bit (bit 3). A control write loads the flag with the written bit 2.
- R12: All 16 control bits are stored and read back as written. The fields the block uses are at the positions given in R3 to R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_ch | input | CH_W | Channel addressed by the write |
| bus_is_data | input | 1 | 1 selects the data register, 0 selects the control register |
| bus_wdata | input | 16 | Write data |
| rd_ch | input | CH_W | Channel addressed by the read |
| rd_is_data | input | 1 | 1 reads the data register, 0 reads the control register |
| rd_data | output | 16 | Read data |
| trig_a | input | 1 | Asynchronous timer trigger A |
| trig_b | input | 1 | Asynchronous timer trigger B |
| ladder_code | output | NUM_CH*12 | Packed ladder codes, channel 0 in the low bits |
| ladder_load | output | NUM_CH | One-cycle strobe marking a new code per channel |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
Four properties are checked on every cycle. A ladder code never moves without its strobe. A strobe always leaves the done flag set. An 8-bit transfer always has a zero low nibble. Linked channels always strobe together. Only the bench's scenarios can show the rest: the exact code values for each format and resolution, the three-edge trigger latency, that the other trigger and a disabled channel are ignored, that the top channel's link bit has no effect, and how the flag interacts with the interrupt enable.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int REG_W    = 16;
    localparam int CODE_W   = 12;
    localparam int NARROW_W = 8;
    localparam int PAD_W    = CODE_W - NARROW_W;

    typedef enum logic [1:0] {
        LD_WRITE  = 2'd0,
        LD_GROUP  = 2'd1,
        LD_TRIG_A = 2'd2,
        LD_TRIG_B = 2'd3
    } load_sel_e;

    // control word, most significant field first
    typedef struct packed {
        logic       out_pin;    // 15
        logic [1:0] ref_pick;   // 14:13
        logic       narrow;     // 12 : 1 = 8-bit
        load_sel_e  load_sel;   // 11:10
        logic       cal_req;    // 9
        logic       span_1x;    // 8
        logic [2:0] amp_mode;   // 7:5
        logic       signed_in;  // 4
        logic       irq_en;     // 3
        logic       done_flag;  // 2
        logic       arm;        // 1
        logic       link_up;    // 0
    } ctl_t;

    typedef enum logic {
        CH_IDLE,
        CH_PEND
    } ch_state_e;

    function automatic logic [CODE_W-1:0] to_ladder(
        input logic [CODE_W-1:0] raw,
        input logic              narrow,
        input logic              signed_in
    );
        logic [CODE_W-1:0] c;
        if (narrow) begin
            c = {raw[NARROW_W-1:0], {PAD_W{1'b0}}};
        end else begin
            c = raw;
        end
        c[CODE_W-1] = c[CODE_W-1] ^ signed_in;
        return c;
    endfunction
endpackage

// File: rtl/dacfe_edge_sync.sv
module dacfe_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], async_in};
        end
    end

    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              dat_wr,
    input  logic              xfer,
    input  logic [REG_W-1:0]  wdata,
    output ctl_t              ctl_q,
    output logic [CODE_W-1:0] shadow_q,
    output logic [CODE_W-1:0] code_q,
    output logic              pend,
    output logic              load_q
);
    ch_state_e         state_q;
    ch_state_e         state_d;
    ctl_t              ctl_d;
    logic [CODE_W-1:0] shadow_d;
    logic [CODE_W-1:0] code_d;

    assign shadow_d = dat_wr ? wdata[CODE_W-1:0] : shadow_q;
    assign code_d   = to_ladder(shadow_d, ctl_q.narrow, ctl_q.signed_in);
    assign pend     = (state_q == CH_PEND);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (dat_wr && !xfer) state_d = CH_PEND;
            CH_PEND: if (xfer)            state_d = CH_IDLE;
            default:                      state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) ctl_d = ctl_t'(wdata);
        if (xfer)   ctl_d.done_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            shadow_q <= '0;
            code_q   <= '0;
            load_q   <= 1'b0;
        end else begin
            ctl_q    <= ctl_d;
            shadow_q <= shadow_d;
            load_q   <= xfer;
            if (xfer) code_q <= code_d;
        end
    end
endmodule

// File: rtl/dacfe_load_ctrl.sv
module dacfe_load_ctrl
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0]   link,
    input  logic [NUM_CH-1:0]   arm,
    input  logic [NUM_CH-1:0]   pend,
    input  logic [NUM_CH-1:0]   dat_wr,
    input  logic [2*NUM_CH-1:0] lsel,
    input  logic                rise_a,
    input  logic                rise_b,
    output logic [NUM_CH-1:0]   xfer
);
    logic [CH_W-1:0]   lead [NUM_CH];
    logic [NUM_CH-1:0] in_grp;
    logic [NUM_CH-1:0] all_pend;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            lead[i] = CH_W'(i);
            if (i > 0) begin
                if (link[(i > 0) ? i - 1 : 0]) lead[i] = lead[(i > 0) ? i - 1 : 0];
            end
        end
        for (int i = 0; i < NUM_CH; i++) begin
            in_grp[i] = (lead[i] != CH_W'(i)) || ((i < NUM_CH - 1) && link[i]);
        end
        for (int l = 0; l < NUM_CH; l++) begin
            all_pend[l] = 1'b1;
            for (int m = 0; m < NUM_CH; m++) begin
                if (lead[m] == CH_W'(l) && !pend[m]) all_pend[l] = 1'b0;
            end
        end
        xfer = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            unique case (load_sel_e'(lsel[{lead[i], 1'b0} +: 2]))
                LD_WRITE:  xfer[i] = in_grp[i] ? (arm[lead[i]] && all_pend[lead[i]]) : dat_wr[i];
                LD_GROUP:  xfer[i] = arm[lead[i]] && (in_grp[i] ? all_pend[lead[i]] : pend[i]);
                LD_TRIG_A: xfer[i] = arm[lead[i]] && rise_a;
                LD_TRIG_B: xfer[i] = arm[lead[i]] && rise_b;
                default:   xfer[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int SYNC_DEPTH = 2,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [CH_W-1:0]          bus_ch,
    input  logic                     bus_is_data,
    input  logic [REG_W-1:0]         bus_wdata,
    input  logic [CH_W-1:0]          rd_ch,
    input  logic                     rd_is_data,
    output logic [REG_W-1:0]         rd_data,
    input  logic                     trig_a,
    input  logic                     trig_b,
    output logic [NUM_CH*CODE_W-1:0] ladder_code,
    output logic [NUM_CH-1:0]        ladder_load,
    output logic [NUM_CH-1:0]        irq
);
    ctl_t              ctl_v    [NUM_CH];
    logic [CODE_W-1:0] shadow_v [NUM_CH];
    logic [CODE_W-1:0] code_v   [NUM_CH];
    logic [NUM_CH-1:0] pend_v, link_v, arm_v, narrow_v, flag_v;
    logic [NUM_CH-1:0] ctl_wr_v, dat_wr_v, xfer_v;
    logic [2*NUM_CH-1:0] lsel_v;
    logic rise_a, rise_b;

    dacfe_edge_sync #(.STAGES(SYNC_DEPTH)) sync_a_i (
        .clk(clk), .rst_n(rst_n), .async_in(trig_a), .rise(rise_a));
    dacfe_edge_sync #(.STAGES(SYNC_DEPTH)) sync_b_i (
        .clk(clk), .rst_n(rst_n), .async_in(trig_b), .rise(rise_b));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ctl_wr_v[i] = bus_we && !bus_is_data && (bus_ch == CH_W'(i));
        assign dat_wr_v[i] = bus_we &&  bus_is_data && (bus_ch == CH_W'(i));

        dacfe_chan chan_i (
            .clk(clk), .rst_n(rst_n),
            .ctl_wr(ctl_wr_v[i]), .dat_wr(dat_wr_v[i]), .xfer(xfer_v[i]),
            .wdata(bus_wdata),
            .ctl_q(ctl_v[i]), .shadow_q(shadow_v[i]), .code_q(code_v[i]),
            .pend(pend_v[i]), .load_q(ladder_load[i]));

        assign link_v[i]              = ctl_v[i].link_up;
        assign arm_v[i]               = ctl_v[i].arm;
        assign narrow_v[i]            = ctl_v[i].narrow;
        assign flag_v[i]              = ctl_v[i].done_flag;
        assign lsel_v[2*i +: 2]       = ctl_v[i].load_sel;
        assign ladder_code[i*CODE_W +: CODE_W] = code_v[i];
        assign irq[i]                 = ctl_v[i].done_flag & ctl_v[i].irq_en;
    end

    dacfe_load_ctrl #(.NUM_CH(NUM_CH)) load_ctrl_i (
        .link(link_v), .arm(arm_v), .pend(pend_v), .dat_wr(dat_wr_v),
        .lsel(lsel_v), .rise_a(rise_a), .rise_b(rise_b), .xfer(xfer_v));

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == CH_W'(i)) begin
                rd_data = rd_is_data ? {{(REG_W-CODE_W){1'b0}}, shadow_v[i]} : REG_W'(ctl_v[i]);
            end
        end
    end
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH*CODE_W-1:0] ladder_code,
    input logic [NUM_CH-1:0]        ladder_load,
    input logic [NUM_CH-1:0]        link_v,
    input logic [NUM_CH-1:0]        narrow_v,
    input logic [NUM_CH-1:0]        flag_v
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_code_only_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !ladder_load[i] |-> $stable(ladder_code[i*CODE_W +: CODE_W]));

        assert_flag_after_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
            ladder_load[i] |-> flag_v[i]);

        assert_narrow_low_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ladder_load[i] && $past(narrow_v[i])) |-> (ladder_code[i*CODE_W +: PAD_W] == '0));

        if (i < NUM_CH - 1) begin : g_pair
            assert_linked_load_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $past(link_v[i]) |-> (ladder_load[i] == ladder_load[i+1]));
        end
    end
endmodule

bind dacfe_top dacfe_checker #(.NUM_CH(NUM_CH)) chk_i (
    .clk(clk), .rst_n(rst_n), .ladder_code(ladder_code), .ladder_load(ladder_load),
    .link_v(link_v), .narrow_v(narrow_v), .flag_v(flag_v));

// File: tb/dacfe_top_tb_top.sv
module dacfe_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int CW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0, bus_ch = 1'b0, bus_is_data = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic rd_ch = 1'b0, rd_is_data = 1'b0;
    logic [15:0] rd_data;
    logic trig_a = 1'b0, trig_b = 1'b0;
    logic [NCH*CW-1:0] ladder_code;
    logic [NCH-1:0] ladder_load, irq;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    int nload [NCH];
    int last_cyc [NCH];
    logic [CW-1:0] exp0 [$], exp1 [$];
    string tag0 [$], tag1 [$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dacfe_top #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_ch(bus_ch),
        .bus_is_data(bus_is_data), .bus_wdata(bus_wdata), .rd_ch(rd_ch),
        .rd_is_data(rd_is_data), .rd_data(rd_data), .trig_a(trig_a), .trig_b(trig_b),
        .ladder_code(ladder_code), .ladder_load(ladder_load), .irq(irq));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cw(bit narrow, logic [1:0] ls, bit sgn, bit ie, bit arm, bit link);
        return {1'b0, 2'b00, narrow, ls, 1'b0, 1'b0, 3'b000, sgn, ie, 1'b0, arm, link};
    endfunction

    task automatic push(input int c, input logic [CW-1:0] v, input string t);
        if (c == 0) begin exp0.push_back(v); tag0.push_back(t); end
        else        begin exp1.push_back(v); tag1.push_back(t); end
    endtask

    // monitor: pops an expected code for every load strobe
    always @(negedge clk) begin
        logic [CW-1:0] got, want;
        string t;
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (ladder_load[c]) begin
                    got = ladder_code[c*CW +: CW];
                    nload[c]++;
                    last_cyc[c] = cyc;
                    if ((c == 0 && exp0.size() == 0) || (c == 1 && exp1.size() == 0)) begin
                        check(1'b0, "R6/R7/R8 unexpected load", 32'(c), 32'hFFFF);
                    end else begin
                        if (c == 0) begin want = exp0.pop_front(); t = tag0.pop_front(); end
                        else        begin want = exp1.pop_front(); t = tag1.pop_front(); end
                        check(got == want, t, 32'(got), 32'(want));
                    end
                end
            end
        end
    end

    task automatic wr(input int ch, input bit is_data, input logic [15:0] v);
        bus_we = 1'b1; bus_ch = 1'(ch); bus_is_data = is_data; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_loads(input int c, input int n, input string req);
        #1;
        check(nload[c] == n, req, 32'(nload[c]), 32'(n));
    endtask

    task automatic rd(input int ch, input bit is_data, output logic [15:0] v);
        rd_ch = 1'(ch); rd_is_data = is_data;
        #1;
        v = rd_data;
    endtask

    task automatic pulse(input bit which_a);
        if (which_a) trig_a = 1'b1; else trig_b = 1'b1;
        idle(4);
        trig_a = 1'b0; trig_b = 1'b0;
        idle(4);
    endtask

    initial begin
        logic [15:0] v;
        nload = '{default: 0};
        last_cyc = '{default: 0};
        idle(3);
        // R1 reset state
        check(ladder_code == '0, "R1 codes after reset", 32'(ladder_code), 0);
        check(ladder_load == '0, "R1 strobes after reset", 32'(ladder_load), 0);
        check(irq == '0, "R1 irq after reset", 32'(irq), 0);
        rd(0, 0, v); check(v == 16'h0, "R1 ctrl reads zero", 32'(v), 0);
        rd(1, 1, v); check(v == 16'h0, "R1 data reads zero", 32'(v), 0);
        rst_n = 1'b1;
        idle(2);

        // R6 + R3 + R2: immediate, 12-bit straight, enable off
        wr(0, 0, cw(0, 2'd0, 0, 0, 0, 0));
        push(0, 12'hABC, "R3 straight 12-bit code");
        wr(0, 1, 16'hFABC);
        expect_loads(0, 1, "R6 immediate load at write edge");
        rd(0, 1, v); check(v == 16'h0ABC, "R2 data readback top nibble zero", 32'(v), 32'h0ABC);

        // R4 two's complement, 12-bit
        wr(0, 0, cw(0, 2'd0, 1, 0, 0, 0));
        push(0, 12'h923, "R4 signed 12-bit positive");
        wr(0, 1, 16'h0123);
        push(0, 12'h000, "R4 signed 12-bit most negative");
        wr(0, 1, 16'h0800);
        expect_loads(0, 3, "R4 loads counted");

        // R5 8-bit straight and signed
        wr(0, 0, cw(1, 2'd0, 0, 0, 0, 0));
        push(0, 12'hA50, "R5 8-bit straight");
        wr(0, 1, 16'hF5A5);
        wr(0, 0, cw(1, 2'd0, 1, 0, 0, 0));
        push(0, 12'h250, "R4 R5 8-bit signed flips bit 7");
        wr(0, 1, 16'h00A5);
        expect_loads(0, 5, "R5 loads counted");

        // R12 control readback of every bit
        wr(1, 0, 16'hE3E0);
        rd(1, 0, v); check(v == 16'hE3E0, "R12 ctrl readback", 32'(v), 32'hE3E0);

        // R7 load on write with enable gating
        wr(1, 0, cw(0, 2'd1, 0, 0, 0, 0));
        push(1, 12'h456, "R7 pending value after enable");
        wr(1, 1, 16'h0456);
        idle(4);
        expect_loads(1, 0, "R7 held while enable low");
        wr(1, 0, cw(0, 2'd1, 0, 0, 1, 0));
        expect_loads(1, 0, "R7 not before next edge");
        idle(1);
        expect_loads(1, 1, "R7 transfer once enabled");

        // R8 trigger A with latency, other trigger ignored, level ignored
        wr(0, 0, cw(0, 2'd2, 0, 0, 1, 0));
        push(0, 12'h321, "R8 trigger A code");
        wr(0, 1, 16'h0321);
        idle(2);
        expect_loads(0, 5, "R8 no load without trigger");
        pulse(0);
        expect_loads(0, 5, "R8 trigger B ignored in mode 2");
        trig_a = 1'b1;
        idle(2);
        expect_loads(0, 5, "R8 not before third edge");
        idle(1);
        expect_loads(0, 6, "R8 load on third edge");
        idle(3);
        expect_loads(0, 6, "R8 held level no retrigger");
        trig_a = 1'b0;
        idle(4);
        wr(0, 0, cw(0, 2'd2, 0, 0, 0, 0));
        pulse(1);
        expect_loads(0, 6, "R8 disabled channel ignores trigger");
        wr(0, 0, cw(0, 2'd3, 0, 0, 1, 0));
        push(0, 12'h654, "R8 trigger B code");
        wr(0, 1, 16'h0654);
        pulse(1);
        expect_loads(0, 6, "R8 trigger A ignored in mode 3");
        pulse(0);
        expect_loads(0, 7, "R8 trigger B loads");

        // R9 grouped, leader mode 1
        wr(1, 0, cw(0, 2'd2, 0, 0, 0, 0));
        wr(0, 0, cw(0, 2'd1, 0, 0, 1, 1));
        push(0, 12'h111, "R9 group ch0 code");
        push(1, 12'h222, "R9 group ch1 code");
        wr(0, 1, 16'h0111);
        idle(3);
        expect_loads(0, 7, "R9 waits for all members");
        wr(1, 1, 16'h0222);
        expect_loads(1, 1, "R9 not at member write edge");
        idle(1);
        expect_loads(0, 8, "R9 ch0 group load");
        expect_loads(1, 2, "R9 ch1 group load");
        check(last_cyc[0] == last_cyc[1], "R9 same cycle", 32'(last_cyc[1]), 32'(last_cyc[0]));

        // R9 grouped with leader mode 0 behaves as mode 1
        wr(0, 0, cw(0, 2'd0, 0, 0, 1, 1));
        push(0, 12'h0AA, "R9 group mode0 ch0");
        push(1, 12'h0BB, "R9 group mode0 ch1");
        wr(0, 1, 16'h00AA);
        idle(2);
        expect_loads(0, 8, "R9 grouped mode 0 not immediate");
        wr(1, 1, 16'h00BB);
        idle(1);
        expect_loads(0, 9, "R9 grouped mode 0 ch0");
        expect_loads(1, 3, "R9 grouped mode 0 ch1");
        check(last_cyc[0] == last_cyc[1], "R9 mode 0 same cycle", 32'(last_cyc[1]), 32'(last_cyc[0]));

        // R10 top channel link bit has no effect
        wr(0, 0, cw(0, 2'd0, 0, 0, 0, 0));
        wr(1, 0, cw(0, 2'd0, 0, 0, 0, 1));
        push(1, 12'h777, "R10 top channel stays immediate");
        wr(1, 1, 16'h0777);
        expect_loads(1, 4, "R10 ch1 immediate despite link");
        push(0, 12'h101, "R10 ch0 independent");
        wr(0, 1, 16'h0101);
        expect_loads(0, 10, "R10 ch0 load");
        expect_loads(1, 4, "R10 ch1 untouched by ch0");

        // R11 flag and interrupt
        wr(0, 0, cw(0, 2'd0, 0, 1, 0, 0));
        #1; check(irq[0] == 1'b0, "R11 flag cleared by ctrl write", 32'(irq[0]), 0);
        push(0, 12'h202, "R11 load sets flag");
        wr(0, 1, 16'h0202);
        #1; check(irq[0] == 1'b1, "R11 irq after load", 32'(irq[0]), 1);
        rd(0, 0, v); check(v[2] == 1'b1, "R11 flag bit 2 readback", 32'(v[2]), 1);
        check(irq[1] == 1'b0, "R11 ch1 no irq without enable", 32'(irq[1]), 0);
        wr(0, 0, cw(0, 2'd0, 0, 1, 0, 0));
        #1; check(irq[0] == 1'b0, "R11 ctrl write clears irq", 32'(irq[0]), 0);
        wr(0, 0, cw(0, 2'd0, 0, 0, 0, 0));
        push(0, 12'h303, "R11 load with irq disabled");
        wr(0, 1, 16'h0303);
        #1; check(irq[0] == 1'b0, "R11 irq gated by enable", 32'(irq[0]), 0);
        rd(0, 0, v); check(v[2] == 1'b1, "R11 flag set while disabled", 32'(v[2]), 1);

        idle(2);
        check(exp0.size() == 0, "R3 all ch0 expected loads seen", 32'(exp0.size()), 0);
        check(exp1.size() == 0, "R3 all ch1 expected loads seen", 32'(exp1.size()), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule